// File: doc/BRIEF.md
# Interleaved Tile Ownership Sequencer

This block sits ahead of the rasterizer in one renderer of a group of one, two or four cooperating chips that share a framebuffer split into square tiles. The tiles are interleaved among the chips in a checkerboard-like pattern. For each primitive, the block receives the screen-space bounding box and decides whether this chip owns any tile that the box touches. A primitive that touches none of the chip's tiles is dropped. The block then reports that it has finished with the primitive and sends no tiles.

When the chip owns at least one tile in the box, the block walks those tiles in row-major tile order and hands one tile coordinate per cycle to the rasterizer over a valid/ready handshake. It skips every tile that belongs to another chip. The tile size, the number of chips and this chip's index are configuration inputs. They are captured when a primitive is accepted. The block takes a new primitive only when it is idle.

Top module: `tile_owner_seq`

## Requirements
- R1: The tile-size code selects the tile edge: 0 = 16 px, 1 = 32 px, 2 = 64 px, 3 = 64 px. A pixel coordinate p maps to tile index p >> (4 + min(code, 2)).
- R2: With chip-count code 2 or 3 (four chips), the tile (tx, ty) belongs to chip index {ty[0], tx[0]}, with ty[0] as the high bit.
- R3: With chip-count code 1 (two chips), the tile belongs to this chip when tx[0] XOR ty[0] equals chip-index bit 0. With chip-count code 0 (one chip), every tile belongs to this chip.
- R4: If the box contains no tile owned by this chip, the block produces no tile. In the first cycle after acceptance it raises `done` for exactly one cycle with `tile_valid` low.
- R5: The emitted tiles are exactly the owned tiles inside the inclusive box, each sent once. They are ordered by ascending row, and by ascending x within a row.
- R6: When the box holds an owned tile, `tile_valid` is low in the first cycle after acceptance. The first tile appears in the second cycle. After that, one tile is transferred in every cycle in which `tile_ready` is high.
- R7: While `tile_valid` is high and `tile_ready` is low, the tile coordinate and `tile_valid` hold in the next cycle.
- R8: `done` is high together with the final tile of an accepted primitive and is low with every earlier tile.
- R9: `prim_ready` is high only while idle and is low whenever `tile_valid` is high. After reset, `prim_ready` is high and `tile_valid` and `done` are low.
- R10: Boxes use 11-bit inclusive pixel coordinates with x0 <= x1 and y0 <= y1, covering a 2048x1536 screen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tile_code | input | 2 | Tile-size code (R1) |
| cfg_chip_code | input | 2 | Chip-count code: 0 one, 1 two, 2/3 four |
| cfg_chip_idx | input | 2 | Index of this chip |
| prim_valid | input | 1 | Primitive box offered |
| prim_ready | output | 1 | Block idle and accepts a box |
| box_x0 | input | 11 | Left pixel, inclusive |
| box_y0 | input | 11 | Top pixel, inclusive |
| box_x1 | input | 11 | Right pixel, inclusive |
| box_y1 | input | 11 | Bottom pixel, inclusive |
| tile_valid | output | 1 | Tile coordinate offered |
| tile_ready | input | 1 | Rasterizer takes the tile |
| tile_x | output | 7 | Tile column |
| tile_y | output | 7 | Tile row |
| done | output | 1 | Primitive finished (last tile or rejected) |

## Verification
The bench targets these corner cases:

- **Boxes one tile wide or one tile tall.** Here ownership must skip whole rows. A walker that only looks one row ahead would stop early, or would emit a foreign tile.
- **Boxes that fall entirely on other chips' tiles.** A broken reject test would hang the walk or emit a tile that does not belong to the chip.
- **A full-screen box at the largest tile size, and the reserved size code 3.** A wrong shift or a wrong clamp changes the tile count.
- **Irregular stalls on the rasterizer side.** A cursor that advances without a handshake would drop or repeat tiles.

The bench also checks the exact cycle of the first tile or the reject pulse, and the position of `done`.

// File: rtl/tos_pkg.sv
package tos_pkg;
  typedef enum logic [1:0] {
    CHIPS_ONE  = 2'd0,
    CHIPS_TWO  = 2'd1,
    CHIPS_FOUR = 2'd2,
    CHIPS_RSVD = 2'd3
  } chip_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REJ  = 2'd1,
    ST_LOAD = 2'd2,
    ST_WALK = 2'd3
  } seq_state_e;

  localparam int unsigned MIN_TILE_LOG2 = 4;
  localparam int unsigned MAX_SIZE_CODE = 2;
endpackage

// File: rtl/tile_owner.sv
module tile_owner
  import tos_pkg::*;
(
  input  logic       tx_lsb,
  input  logic       ty_lsb,
  input  logic [1:0] chip_code,
  input  logic [1:0] chip_idx,
  output logic       owned
);
  always_comb begin
    case (chip_mode_e'(chip_code))
      CHIPS_ONE: owned = 1'b1;
      CHIPS_TWO: owned = ((tx_lsb ^ ty_lsb) == chip_idx[0]);
      default:   owned = (ty_lsb == chip_idx[1]) && (tx_lsb == chip_idx[0]);
    endcase
  end
endmodule

// File: rtl/tile_row_probe.sv
module tile_row_probe #(
  parameter int unsigned TW = 8
) (
  input  logic [TW-1:0] row,
  input  logic [TW-1:0] x_from,
  input  logic [TW-1:0] x_last,
  input  logic [TW-1:0] y_last,
  input  logic [1:0]    chip_code,
  input  logic [1:0]    chip_idx,
  output logic          hit,
  output logic [TW-1:0] x_hit
);
  logic          own_here;
  logic          own_next;
  logic [TW-1:0] x_plus;

  assign x_plus = x_from + TW'(1);

  tile_owner u_own_here (
    .tx_lsb(x_from[0]), .ty_lsb(row[0]),
    .chip_code(chip_code), .chip_idx(chip_idx), .owned(own_here)
  );
  tile_owner u_own_next (
    .tx_lsb(x_plus[0]), .ty_lsb(row[0]),
    .chip_code(chip_code), .chip_idx(chip_idx), .owned(own_next)
  );

  always_comb begin
    x_hit = own_here ? x_from : x_plus;
    hit   = 1'b0;
    if (row <= y_last) begin
      if (own_here)      hit = (x_from <= x_last);
      else if (own_next) hit = (x_plus <= x_last);
    end
  end
endmodule

// File: rtl/tile_search.sv
module tile_search #(
  parameter int unsigned TW = 8,
  parameter int unsigned ROWS_AHEAD = 3
) (
  input  logic [TW-1:0] start_x,
  input  logic [TW-1:0] start_y,
  input  logic [TW-1:0] tx0,
  input  logic [TW-1:0] tx1,
  input  logic [TW-1:0] ty1,
  input  logic [1:0]    chip_code,
  input  logic [1:0]    chip_idx,
  output logic          found,
  output logic [TW-1:0] next_x,
  output logic [TW-1:0] next_y
);
  logic [ROWS_AHEAD-1:0] hit;
  logic [TW-1:0]         hx [ROWS_AHEAD];
  logic [TW-1:0]         hy [ROWS_AHEAD];

  for (genvar g = 0; g < ROWS_AHEAD; g++) begin : g_row
    logic [TW-1:0] xs;
    assign hy[g] = start_y + TW'(g);
    assign xs    = (g == 0) ? start_x : tx0;
    tile_row_probe #(.TW(TW)) u_probe (
      .row(hy[g]), .x_from(xs), .x_last(tx1), .y_last(ty1),
      .chip_code(chip_code), .chip_idx(chip_idx),
      .hit(hit[g]), .x_hit(hx[g])
    );
  end

  always_comb begin
    found  = 1'b0;
    next_x = hx[ROWS_AHEAD-1];
    next_y = hy[ROWS_AHEAD-1];
    for (int i = ROWS_AHEAD - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found  = 1'b1;
        next_x = hx[i];
        next_y = hy[i];
      end
    end
  end
endmodule

// File: rtl/tile_reject_test.sv
module tile_reject_test #(
  parameter int unsigned TW = 8
) (
  input  logic [TW-1:0] tx0,
  input  logic [TW-1:0] tx1,
  input  logic [TW-1:0] ty0,
  input  logic [TW-1:0] ty1,
  input  logic [1:0]    chip_code,
  input  logic [1:0]    chip_idx,
  output logic          any_owned
);
  logic       wide_x;
  logic       wide_y;
  logic [3:0] cand;

  assign wide_x = (tx1 != tx0);
  assign wide_y = (ty1 != ty0);

  for (genvar j = 0; j < 2; j++) begin : g_py
    for (genvar i = 0; i < 2; i++) begin : g_px
      logic own;
      tile_owner u_own (
        .tx_lsb(tx0[0] ^ 1'(i)), .ty_lsb(ty0[0] ^ 1'(j)),
        .chip_code(chip_code), .chip_idx(chip_idx), .owned(own)
      );
      assign cand[j*2+i] = own && ((i == 0) || wide_x) && ((j == 0) || wide_y);
    end
  end

  assign any_owned = |cand;
endmodule

// File: rtl/tile_owner_seq.sv
module tile_owner_seq
  import tos_pkg::*;
#(
  parameter int unsigned SCR_W = 11,
  localparam int unsigned TO_W = SCR_W - MIN_TILE_LOG2,
  localparam int unsigned TW   = TO_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_tile_code,
  input  logic [1:0]       cfg_chip_code,
  input  logic [1:0]       cfg_chip_idx,
  input  logic             prim_valid,
  output logic             prim_ready,
  input  logic [SCR_W-1:0] box_x0,
  input  logic [SCR_W-1:0] box_y0,
  input  logic [SCR_W-1:0] box_x1,
  input  logic [SCR_W-1:0] box_y1,
  output logic             tile_valid,
  input  logic             tile_ready,
  output logic [TO_W-1:0]  tile_x,
  output logic [TO_W-1:0]  tile_y,
  output logic             done
);
  function automatic logic [TW-1:0] to_tile(input logic [SCR_W-1:0] p,
                                            input logic [1:0] code);
    logic [SCR_W-1:0] s;
    case (code)
      2'd0:    s = p >> MIN_TILE_LOG2;
      2'd1:    s = p >> (MIN_TILE_LOG2 + 1);
      default: s = p >> (MIN_TILE_LOG2 + MAX_SIZE_CODE);
    endcase
    return s[TW-1:0];
  endfunction

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tx0_q, tx1_q, ty0_q, ty1_q;
  logic [TW-1:0] cx_q, cy_q, cx_d, cy_d;
  logic [1:0]    chip_code_q, chip_idx_q;
  logic          box_en, cur_en;

  logic [TW-1:0] in_tx0, in_tx1, in_ty0, in_ty1;
  logic          in_owned;
  logic [TW-1:0] srch_x, srch_y, nx, ny;
  logic          nfound;

  assign in_tx0 = to_tile(box_x0, cfg_tile_code);
  assign in_tx1 = to_tile(box_x1, cfg_tile_code);
  assign in_ty0 = to_tile(box_y0, cfg_tile_code);
  assign in_ty1 = to_tile(box_y1, cfg_tile_code);

  tile_reject_test #(.TW(TW)) u_reject (
    .tx0(in_tx0), .tx1(in_tx1), .ty0(in_ty0), .ty1(in_ty1),
    .chip_code(cfg_chip_code), .chip_idx(cfg_chip_idx),
    .any_owned(in_owned)
  );

  assign srch_x = (state_q == ST_WALK) ? (cx_q + TW'(1)) : tx0_q;
  assign srch_y = (state_q == ST_WALK) ? cy_q : ty0_q;

  tile_search #(.TW(TW), .ROWS_AHEAD(3)) u_search (
    .start_x(srch_x), .start_y(srch_y),
    .tx0(tx0_q), .tx1(tx1_q), .ty1(ty1_q),
    .chip_code(chip_code_q), .chip_idx(chip_idx_q),
    .found(nfound), .next_x(nx), .next_y(ny)
  );

  always_comb begin
    state_d    = state_q;
    box_en     = 1'b0;
    cur_en     = 1'b0;
    cx_d       = nx;
    cy_d       = ny;
    prim_ready = 1'b0;
    tile_valid = 1'b0;
    done       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        prim_ready = 1'b1;
        if (prim_valid) begin
          box_en  = 1'b1;
          state_d = in_owned ? ST_LOAD : ST_REJ;
        end
      end
      ST_REJ: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      ST_LOAD: begin
        cur_en  = 1'b1;
        state_d = ST_WALK;
      end
      default: begin
        tile_valid = 1'b1;
        done       = !nfound;
        if (tile_ready) begin
          if (nfound) cur_en  = 1'b1;
          else        state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx0_q       <= '0;
      tx1_q       <= '0;
      ty0_q       <= '0;
      ty1_q       <= '0;
      chip_code_q <= '0;
      chip_idx_q  <= '0;
    end else if (box_en) begin
      tx0_q       <= in_tx0;
      tx1_q       <= in_tx1;
      ty0_q       <= in_ty0;
      ty1_q       <= in_ty1;
      chip_code_q <= cfg_chip_code;
      chip_idx_q  <= cfg_chip_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx_q <= '0;
      cy_q <= '0;
    end else if (cur_en) begin
      cx_q <= cx_d;
      cy_q <= cy_d;
    end
  end

  assign tile_x = cx_q[TO_W-1:0];
  assign tile_y = cy_q[TO_W-1:0];
endmodule

// File: rtl/tile_owner_seq_chk.sv
module tile_owner_seq_chk #(
  parameter int unsigned SCR_W = 11,
  localparam int unsigned TO_W = SCR_W - 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_tile_code,
  input logic [1:0]       cfg_chip_code,
  input logic [1:0]       cfg_chip_idx,
  input logic             prim_valid,
  input logic             prim_ready,
  input logic [SCR_W-1:0] box_x0,
  input logic [SCR_W-1:0] box_y0,
  input logic [SCR_W-1:0] box_x1,
  input logic [SCR_W-1:0] box_y1,
  input logic             tile_valid,
  input logic             tile_ready,
  input logic [TO_W-1:0]  tile_x,
  input logic [TO_W-1:0]  tile_y,
  input logic             done
);
  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid |-> !prim_ready);

  // R9
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_valid && prim_ready) |=> !prim_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid && !tile_ready) |=> (tile_valid && $stable(tile_x) && $stable(tile_y)));

  // R4
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tile_valid) |=> !done);

  // R2
  four_chip_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid && cfg_chip_code[1]) |-> ({tile_y[0], tile_x[0]} == cfg_chip_idx));

  // R3
  two_chip_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid && cfg_chip_code == 2'd1) |-> ((tile_x[0] ^ tile_y[0]) == cfg_chip_idx[0]));

  // R8
  done_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid && tile_ready && done) |=> (!tile_valid && prim_ready));
endmodule

bind tile_owner_seq tile_owner_seq_chk #(.SCR_W(SCR_W)) u_chk (.*);

// File: tb/tb_tile_owner_seq.sv
`timescale 1ns/1ps
module tb_tile_owner_seq;
  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_tile_code, cfg_chip_code, cfg_chip_idx;
  logic        prim_valid, prim_ready;
  logic [10:0] box_x0, box_y0, box_x1, box_y1;
  logic        tile_valid, tile_ready, done;
  logic [6:0]  tile_x, tile_y;

  int checks = 0;
  int failures = 0;
  int ex_x [4096];
  int ex_y [4096];
  int ex_n;

  tile_owner_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_tile_code(cfg_tile_code), .cfg_chip_code(cfg_chip_code),
    .cfg_chip_idx(cfg_chip_idx),
    .prim_valid(prim_valid), .prim_ready(prim_ready),
    .box_x0(box_x0), .box_y0(box_y0), .box_x1(box_x1), .box_y1(box_y1),
    .tile_valid(tile_valid), .tile_ready(tile_ready),
    .tile_x(tile_x), .tile_y(tile_y), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_owned(int tx, int ty, int chips, int idx);
    if (chips == 0) return 1'b1;
    if (chips == 1) return ((tx ^ ty) & 1) == (idx & 1);
    return (((ty & 1) << 1) | (tx & 1)) == idx;
  endfunction

  // R1: tile edge from size code, code 3 acts as 64 px
  function automatic int ref_shift(int code);
    return (code >= 2) ? 6 : 4 + code;
  endfunction

  task automatic run_prim(input int x0, input int y0, input int x1, input int y1,
                          input int chips, input int idx, input int code,
                          input int stall, input string req);
    int sh, n, cyc, px, py;
    bit seen_done, got_reject, prev_stall, first_seen;
    sh = ref_shift(code);
    ex_n = 0;
    for (int ty = (y0 >> sh); ty <= (y1 >> sh); ty++)
      for (int tx = (x0 >> sh); tx <= (x1 >> sh); tx++)
        if (ref_owned(tx, ty, chips, idx)) begin
          ex_x[ex_n] = tx; ex_y[ex_n] = ty; ex_n++;
        end
    @(negedge clk);
    check(prim_ready == 1'b1, "R9", "idle before accept", int'(prim_ready), 1);
    cfg_tile_code = 2'(code); cfg_chip_code = 2'(chips); cfg_chip_idx = 2'(idx);
    box_x0 = 11'(x0); box_y0 = 11'(y0); box_x1 = 11'(x1); box_y1 = 11'(y1);
    prim_valid = 1'b1;
    @(negedge clk);
    prim_valid = 1'b0;
    n = 0; cyc = 1; seen_done = 0; got_reject = 0; prev_stall = 0; first_seen = 0;
    px = 0; py = 0;
    while (!seen_done && cyc < 20000) begin
      tile_ready = (stall == 0) || ((cyc % stall) != 0);
      #1;
      if (cyc == 1) begin
        check(tile_valid == 1'b0, "R6", "valid in cycle after accept", int'(tile_valid), 0);
        check(done == (ex_n == 0), "R4", "done in cycle after accept", int'(done), int'(ex_n == 0));
      end
      if (tile_valid) begin
        if (!first_seen) begin
          first_seen = 1;
          check(cyc == 2, "R6", "first tile cycle", cyc, 2);
          check(prim_ready == 1'b0, "R9", "ready while busy", int'(prim_ready), 0);
        end
        if (prev_stall) begin
          check(tile_x == 7'(px) && tile_y == 7'(py), "R7", "tile held under stall",
                int'(tile_x) * 1000 + int'(tile_y), px * 1000 + py);
        end
        px = tile_x; py = tile_y;
        prev_stall = !tile_ready;
        if (tile_ready) begin
          if (n < ex_n) begin
            check(tile_x == 7'(ex_x[n]) && tile_y == 7'(ex_y[n]), req, "tile order",
                  int'(tile_x) * 1000 + int'(tile_y), ex_x[n] * 1000 + ex_y[n]);
            check(done == (n == ex_n - 1), "R8", "done with last tile", int'(done),
                  int'(n == ex_n - 1));
          end else begin
            check(1'b0, req, "extra tile", n, ex_n);
          end
          n++;
          if (done) seen_done = 1;
        end
      end else if (done) begin
        got_reject = 1;
        seen_done = 1;
      end
      @(negedge clk);
      cyc++;
    end
    tile_ready = 1'b0;
    check(got_reject == (ex_n == 0), "R4", "reject decision", int'(got_reject), int'(ex_n == 0));
    check(n == ex_n, "R5", "tile count", n, ex_n);
    #1;
    check(prim_ready == 1'b1 && tile_valid == 1'b0 && done == 1'b0, "R9", "idle after done",
          int'(prim_ready), 1);
  endtask

  task automatic t_reset();
    #1;
    check(prim_ready == 1'b1, "R9", "reset prim_ready", int'(prim_ready), 1);
    check(tile_valid == 1'b0, "R9", "reset tile_valid", int'(tile_valid), 0);
    check(done == 1'b0, "R9", "reset done", int'(done), 0);
  endtask

  task automatic t_single_chip();
    run_prim(5, 5, 40, 20, 0, 0, 0, 0, "R3");
    run_prim(0, 0, 127, 127, 0, 3, 1, 3, "R1");
  endtask

  task automatic t_two_chips();
    run_prim(0, 0, 130, 100, 1, 1, 1, 0, "R3");
    run_prim(48, 0, 63, 95, 1, 0, 0, 0, "R3");
    run_prim(17, 33, 200, 47, 1, 1, 0, 4, "R5");
  endtask

  task automatic t_four_chips();
    for (int id = 0; id < 4; id++) run_prim(10, 70, 300, 260, 2, id, 2, 3, "R2");
    run_prim(32, 0, 47, 150, 3, 2, 0, 0, "R2");
  endtask

  task automatic t_rejects();
    run_prim(1, 1, 14, 14, 2, 3, 0, 0, "R4");
    run_prim(16, 0, 31, 15, 1, 0, 0, 0, "R4");
    run_prim(32, 0, 47, 200, 2, 1, 0, 0, "R4");
    run_prim(0, 64, 500, 127, 2, 0, 2, 0, "R4");
  endtask

  task automatic t_full_screen();
    run_prim(0, 0, 2047, 1535, 2, 2, 3, 0, "R10");
    run_prim(2000, 1500, 2047, 1535, 1, 1, 0, 2, "R10");
  endtask

  initial begin
    rst_n = 1'b0; prim_valid = 1'b0; tile_ready = 1'b0;
    cfg_tile_code = '0; cfg_chip_code = '0; cfg_chip_idx = '0;
    box_x0 = '0; box_y0 = '0; box_x1 = '0; box_y1 = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single_chip();
    t_two_chips();
    t_four_chips();
    t_rejects();
    t_full_screen();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule